// File: doc/BRIEF.md
# Video RAM Address Multiplexer

The block chooses the 12-bit address presented to the tile-code and tile-colour RAM of a raster video system. The bus is shared in time: while timing bit 2H is low the processor's address passes through; while it is high the video fetch address is driven. The video fetch address is built from the horizontal timing bits 2H to 128H, the inverted 256H bit and the vertical row bits 8V to 128V.

There are three video fetch modes. During the visible playfield the column and row bits index the tile map directly. On the horizontal region used for the top and bottom status rows, a scrambled address built from repeated timing bits reaches the RAM cells the playfield leaves unused. In the remaining off-screen slots the motion-object attribute table at the top of the address space is read. Bit 10 of the address is 4H in the first two modes, so a tile's code and its colour come from consecutive slots. The block also decodes the first attribute byte of each motion object it fetches into an image number and two mirror flags, and registers them together with a bus-owner flag for downstream latching.

Top module: `vram_addr_mux`

## Requirements
- R1: While `h_tick[0]` (2H) is 0, `ram_addr` equals `cpu_addr` combinationally, whatever the timing inputs are.
- R2: With 2H = 1 and `h256_n` = 1, `ram_addr` = {0, 4H, 128V, 64V, 32V, 16V, 8V, 128H, 64H, 32H, 16H, 8H}, where `h_tick[6:0]` = {128H, 64H, 32H, 16H, 8H, 4H, 2H} and `v_row[4:0]` = {128V, 64V, 32V, 16V, 8V}.
- R3: In the playfield and status modes, bit 11 is 0 and bit 10 equals 4H, so the code (4H = 0) and the colour (4H = 1, offset +0x400) of one tile are read on consecutive video slots.
- R4: With 2H = 1, `h256_n` = 0 and 16H = 32H = 64H, `ram_addr` = {0, 4H, 64H, 64H, 64H, 64H, 8H, 128V, 64V, 32V, 16V, 8V}.
- R5: With 2H = 1, `h256_n` = 0 and 16H, 32H, 64H not all equal, `ram_addr` = 0xFF0 + {64H, 32H, 16H, 4H}, inside the attribute table 0xFF0 to 0xFFF.
- R6: `video_owns` is 0 in reset and otherwise equals the 2H value sampled at the previous rising clock edge.
- R7: At a rising edge where 2H = 1, the motion-object mode of R5 is active and 4H = 0, the first attribute byte on `rd_data` is decoded: `obj_image` takes bits 7:2, `obj_xflip` bit 1 and `obj_yflip` bit 0.
- R8: At any other edge `rd_data` is ignored and `obj_image`, `obj_xflip` and `obj_yflip` hold their values.
- R9: Synchronous active-high reset clears `video_owns`, `obj_image`, `obj_xflip` and `obj_yflip`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 12 | Processor address into the RAM window |
| h_tick | input | 7 | Horizontal timing bits {128H..2H} |
| h256_n | input | 1 | Inverted 256H bit, high over the playfield |
| v_row | input | 5 | Vertical timing bits {128V..8V} |
| rd_data | input | 8 | Byte read back from the RAM |
| ram_addr | output | 12 | Address to the RAM |
| video_owns | output | 1 | Registered bus-owner flag, 1 for video |
| obj_image | output | 6 | Registered image number of the last object fetched |
| obj_xflip | output | 1 | Registered horizontal mirror flag |
| obj_yflip | output | 1 | Registered vertical mirror flag |

## Verification
A wrong mode decode shows at once on `ram_addr` as an address in the wrong region, for example a status-row slot that lands in the attribute table, so the sweep over every timing combination exposes it in the same cycle. A bad owner register shows one edge later on `video_owns`. A decode latch that loads on the wrong slot or at the wrong bit positions shows on the object outputs at the edge after the byte is offered and persists until the next valid load, which makes the hold cases as telling as the load cases.

// File: rtl/vra_pkg.sv
package vra_pkg;

    localparam int ADDR_W   = 12;
    localparam int HBITS    = 7;
    localparam int VBITS    = 5;
    localparam logic [7:0] OBJ_BASE_HI = 8'hFF;

    typedef enum logic [1:0] {
        FETCH_PLAY   = 2'd0,
        FETCH_BORDER = 2'd1,
        FETCH_OBJ    = 2'd2
    } fetch_mode_e;

    typedef struct packed {
        logic       h128;
        logic       h64;
        logic       h32;
        logic       h16;
        logic       h8;
        logic       h4;
        logic       h2;
    } htick_t;

    typedef struct packed {
        logic       v128;
        logic       v64;
        logic       v32;
        logic       v16;
        logic       v8;
    } vrow_t;

    function automatic logic [ADDR_W-1:0] play_addr(htick_t h, vrow_t v);
        return {1'b0, h.h4, v.v128, v.v64, v.v32, v.v16, v.v8,
                h.h128, h.h64, h.h32, h.h16, h.h8};
    endfunction

    function automatic logic [ADDR_W-1:0] border_addr(htick_t h, vrow_t v);
        return {1'b0, h.h4, {4{h.h64}}, h.h8,
                v.v128, v.v64, v.v32, v.v16, v.v8};
    endfunction

    function automatic logic [ADDR_W-1:0] obj_addr(htick_t h);
        return {OBJ_BASE_HI, h.h64, h.h32, h.h16, h.h4};
    endfunction

endpackage

// File: rtl/vra_mode_sel.sv
module vra_mode_sel
    import vra_pkg::*;
(
    input  htick_t      h,
    input  logic        h256_n,
    output fetch_mode_e mode
);
    logic col_uniform;

    always_comb begin
        col_uniform = (h.h16 == h.h32) && (h.h32 == h.h64);
        if (h256_n)
            mode = FETCH_PLAY;
        else if (col_uniform)
            mode = FETCH_BORDER;
        else
            mode = FETCH_OBJ;
    end
endmodule

// File: rtl/vra_addr_form.sv
module vra_addr_form
    import vra_pkg::*;
(
    input  fetch_mode_e       mode,
    input  htick_t            h,
    input  vrow_t             v,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic [ADDR_W-1:0] ram_addr
);
    logic [ADDR_W-1:0] vid_addr;

    always_comb begin
        unique case (mode)
            FETCH_PLAY:   vid_addr = play_addr(h, v);
            FETCH_BORDER: vid_addr = border_addr(h, v);
            default:      vid_addr = obj_addr(h);
        endcase
    end

    // Per-bit owner steering; 2H picks the master for every address line.
    for (genvar b = 0; b < ADDR_W; b++) begin : g_steer
        assign ram_addr[b] = h.h2 ? vid_addr[b] : cpu_addr[b];
    end
endmodule

// File: rtl/vra_obj_decode.sv
module vra_obj_decode
    import vra_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int IMG_W = DATA_W - 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] byte_in,
    output logic [IMG_W-1:0]  image,
    output logic              xflip,
    output logic              yflip
);
    always_ff @(posedge clk) begin
        if (rst) begin
            image <= '0;
            xflip <= 1'b0;
            yflip <= 1'b0;
        end else if (load) begin
            image <= byte_in[DATA_W-1:2];
            xflip <= byte_in[1];
            yflip <= byte_in[0];
        end
    end
endmodule

// File: rtl/vram_addr_mux.sv
module vram_addr_mux
    import vra_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int IMG_W = DATA_W - 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [HBITS-1:0]  h_tick,
    input  logic              h256_n,
    input  logic [VBITS-1:0]  v_row,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              video_owns,
    output logic [IMG_W-1:0]  obj_image,
    output logic              obj_xflip,
    output logic              obj_yflip
);
    htick_t      h;
    vrow_t       v;
    fetch_mode_e mode;
    logic        obj_load;

    assign h = htick_t'(h_tick);
    assign v = vrow_t'(v_row);

    vra_mode_sel u_mode (
        .h      (h),
        .h256_n (h256_n),
        .mode   (mode)
    );

    vra_addr_form u_form (
        .mode     (mode),
        .h        (h),
        .v        (v),
        .cpu_addr (cpu_addr),
        .ram_addr (ram_addr)
    );

    // First attribute byte of an object sits on the even slot (4H low).
    assign obj_load = h.h2 && (mode == FETCH_OBJ) && !h.h4;

    vra_obj_decode #(.DATA_W(DATA_W)) u_obj (
        .clk     (clk),
        .rst     (rst),
        .load    (obj_load),
        .byte_in (rd_data),
        .image   (obj_image),
        .xflip   (obj_xflip),
        .yflip   (obj_yflip)
    );

    always_ff @(posedge clk) begin
        if (rst) video_owns <= 1'b0;
        else     video_owns <= h.h2;
    end
endmodule

// File: rtl/vram_addr_mux_chk.sv
module vram_addr_mux_chk (
    input logic        clk,
    input logic        rst,
    input logic [11:0] cpu_addr,
    input logic [6:0]  h_tick,
    input logic        h256_n,
    input logic [7:0]  rd_data,
    input logic [11:0] ram_addr,
    input logic        video_owns,
    input logic [5:0]  obj_image,
    input logic        obj_xflip,
    input logic        obj_yflip
);
    logic obj_slot;
    assign obj_slot = !h256_n &&
                      !((h_tick[3] == h_tick[4]) && (h_tick[4] == h_tick[5]));

    // R1
    cpu_pass_chk: assert property (@(posedge clk) disable iff (rst)
        !h_tick[0] |-> ram_addr == cpu_addr);

    // R3
    tile_half_chk: assert property (@(posedge clk) disable iff (rst)
        (h_tick[0] && !obj_slot) |-> (!ram_addr[11] && ram_addr[10] == h_tick[1]));

    // R5
    obj_region_chk: assert property (@(posedge clk) disable iff (rst)
        (h_tick[0] && obj_slot) |-> ram_addr[11:4] == 8'hFF);

    // R6
    owner_lag_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> video_owns == $past(h_tick[0]));

    // R7
    obj_load_chk: assert property (@(posedge clk) disable iff (rst)
        (h_tick[0] && obj_slot && !h_tick[1]) |=>
            (obj_image == $past(rd_data[7:2]) && obj_xflip == $past(rd_data[1])
             && obj_yflip == $past(rd_data[0])));

    // R8
    obj_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(h_tick[0] && obj_slot && !h_tick[1]) |=>
            ($stable(obj_image) && $stable(obj_xflip) && $stable(obj_yflip)));
endmodule

bind vram_addr_mux vram_addr_mux_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cpu_addr   (cpu_addr),
    .h_tick     (h_tick),
    .h256_n     (h256_n),
    .rd_data    (rd_data),
    .ram_addr   (ram_addr),
    .video_owns (video_owns),
    .obj_image  (obj_image),
    .obj_xflip  (obj_xflip),
    .obj_yflip  (obj_yflip)
);

// File: tb/test_vram_addr_mux.sv
module test_vram_addr_mux;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] cpu_addr = '0;
    logic [6:0]  h_tick = '0;
    logic        h256_n = 1'b1;
    logic [4:0]  v_row = '0;
    logic [7:0]  rd_data = '0;
    logic [11:0] ram_addr;
    logic        video_owns;
    logic [5:0]  obj_image;
    logic        obj_xflip, obj_yflip;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    vram_addr_mux i_vram_addr_mux (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .h_tick(h_tick),
        .h256_n(h256_n), .v_row(v_row), .rd_data(rd_data),
        .ram_addr(ram_addr), .video_owns(video_owns),
        .obj_image(obj_image), .obj_xflip(obj_xflip), .obj_yflip(obj_yflip)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int model_addr(int h, int hn, int v, int cpu);
        int b2  = h & 1;
        int b4  = (h >> 1) & 1;
        int b8  = (h >> 2) & 1;
        int b16 = (h >> 3) & 1;
        int b32 = (h >> 4) & 1;
        int b64 = (h >> 5) & 1;
        if (b2 == 0) return cpu;
        if (hn == 1) return b4 * 1024 + v * 32 + (h >> 2);
        if (b16 == b32 && b32 == b64)
            return b4 * 1024 + b64 * 960 + b8 * 32 + v;
        return 4080 + b64 * 8 + b32 * 4 + b16 * 2 + b4;
    endfunction

    task automatic obj_step(int h, int hn, int data);
        @(negedge clk);
        h_tick  = 7'(h);
        h256_n  = 1'(hn);
        rd_data = 8'(data);
        @(posedge clk);
        #1;
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R9 reset state
        chk("R9 owner", video_owns, 0);
        chk("R9 image", obj_image, 0);
        chk("R9 flips", {obj_xflip, obj_yflip}, 0);
        @(negedge clk);
        rst = 1'b0;

        // R1 R2 R3 R4 R5 R6: full sweep of timing inputs
        for (int hn = 0; hn < 2; hn++) begin
            for (int v = 0; v < 32; v++) begin
                for (int h = 0; h < 128; h++) begin
                    int ca;
                    string tag;
                    ca = ((h * 37) + (v * 301) + hn * 2047 + 5) & 12'hFFF;
                    @(negedge clk);
                    cpu_addr = 12'(ca);
                    h_tick   = 7'(h);
                    h256_n   = 1'(hn);
                    v_row    = 5'(v);
                    rd_data  = 8'h00;
                    #1;
                    if ((h & 1) == 0) tag = "R1";
                    else if (hn == 1) tag = "R2 R3";
                    else if (((h >> 3) & 7) == 0 || ((h >> 3) & 7) == 7) tag = "R4 R3";
                    else tag = "R5";
                    chk(tag, ram_addr, model_addr(h, hn, v, ca));
                    @(posedge clk);
                    #1;
                    chk("R6", video_owns, h & 1);
                end
            end
        end

        // R7 load on even object slot: 2H=1, 4H=0, 16H=1, h256_n=0
        obj_step(7'b0001001, 0, 8'hA6);
        chk("R7 image", obj_image, 6'h29);
        chk("R7 xflip", obj_xflip, 1);
        chk("R7 yflip", obj_yflip, 0);
        // R8 odd slot (colour byte) ignored
        obj_step(7'b0001011, 0, 8'h55);
        chk("R8 odd slot", {obj_image, obj_xflip, obj_yflip}, 8'hA6);
        // R8 cpu slot ignored
        obj_step(7'b0001000, 0, 8'h3C);
        chk("R8 cpu slot", {obj_image, obj_xflip, obj_yflip}, 8'hA6);
        // R8 playfield ignored
        obj_step(7'b0001001, 1, 8'h3C);
        chk("R8 playfield", {obj_image, obj_xflip, obj_yflip}, 8'hA6);
        // R8 status rows ignored (16H=32H=64H=1)
        obj_step(7'b0111001, 0, 8'h3C);
        chk("R8 status", {obj_image, obj_xflip, obj_yflip}, 8'hA6);
        // R7 second load, other slot and pattern
        obj_step(7'b1100001, 0, 8'h7D);
        chk("R7 image 2", obj_image, 6'h1F);
        chk("R7 flips 2", {obj_xflip, obj_yflip}, 2'b01);

        // R9 reset clears again
        @(negedge clk);
        rst = 1'b1;
        h_tick = 7'b0000001;
        @(posedge clk);
        #1;
        chk("R9 image after", obj_image, 0);
        chk("R9 owner after", video_owns, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule